// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block sends words on a clocked synchronous serial line whose shift clock comes from an external master. A CPU-side interface writes 8-bit words, with an optional ninth bit, into a holding register. When the shift register is idle, the held word moves into it and the bits go out one per external clock. A word written while another is shifting waits in the holding register. It transfers the moment the last bit of the current word is done.

A ready flag shows whether the holding register can take a word. A shift-empty status bit shows whether the shift register is idle. An interrupt request is the ready flag gated by an enable. Mode decoding drives the data pin only in slave transmit mode. That mode needs the port enabled, synchronous mode, the external clock source, both receive enables off, address detection off and transmit enabled. The external clock is brought into the system clock domain through a synchronizer, and its falling edges are detected there.

Top module: `sync_slave_tx`

## Requirements
- R1: `sd_oe` is 1 only when all of these hold: en_port=1, mode_sync=1, clk_master=0, rx_single=0, rx_cont=0, addr_detect=0 and en_tx=1. Any other combination gives `sd_oe`=0.
- R2: After reset, `ready_flag`=1, `shift_empty`=1, `irq`=0 and `sd_oe`=0, with all control inputs at 0.
- R3: A write to an empty holding register while the shifter is idle moves into the shift register within two system clocks. `shift_empty` then reads 0 and `ready_flag` returns to 1.
- R4: A word written while another is shifting stays held, with `ready_flag`=0. After the falling external clock edge that ends the current word, the held word starts shifting. `ready_flag` then reads 1 and `shift_empty` stays 0.
- R5: Bits leave least significant first. Bit 0 is on `sd_out` from the load onward. Each falling edge of `ext_sck` advances one bit, so the master samples on rising edges. `sd_out` is 1 while no word is shifting.
- R6: With nine_en=1 at the write, the frame is 9 bits, and the value of ninth_bit at the write is sent after data bit 7. With nine_en=0 the frame is 8 bits.
- R7: A write made while the holding register is full is ignored, and its data is never sent.
- R8: `irq` equals `ready_flag` AND irq_en.
- R9: `shift_empty` becomes 1 when the final bit of a word completes and no word is held.
- R10: While slave transmit mode is inactive, both registers are flushed (`shift_empty`=1, `ready_flag`=1) and writes are ignored.
- R11: A write arriving in the same cycles as the falling edge that ends the current word is transmitted intact as the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_port | input | 1 | Serial port enable |
| mode_sync | input | 1 | Synchronous mode select |
| clk_master | input | 1 | 1 = block sources the clock (not slave) |
| rx_single | input | 1 | Single-word receive enable |
| rx_cont | input | 1 | Continuous receive enable |
| addr_detect | input | 1 | Address-detect mode enable |
| en_tx | input | 1 | Transmit enable |
| nine_en | input | 1 | 9-bit frame select, sampled at write |
| ninth_bit | input | 1 | Ninth data bit, sampled at write |
| irq_en | input | 1 | Transmit interrupt enable |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_wdata | input | DATA_W | Low data bits written |
| ext_sck | input | 1 | External shift clock from the master |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Output enable for the data pin |
| ready_flag | output | 1 | Holding register empty |
| shift_empty | output | 1 | Shift register idle |
| irq | output | 1 | Transmit interrupt request |

## Verification
A CPU write and the reload of the shifter from the holding register can fall in the same system clock. The reload happens on the falling edge that ends a word, and it races a new write into the emptied holding register. The bench provokes this by issuing the write at each offset of zero to four system clocks after the final falling edge of `ext_sck`. The synchronizer delay therefore lands before, on, and after the reload cycle. Each case is judged by the scoreboard: the master-side monitor must see every bit of the new word, in order, and nothing else.

// File: rtl/sstx_pkg.sv
package sstx_pkg;

   typedef struct packed {
      logic port_en;
      logic sync_mode;
      logic clk_master;
      logic rx_single;
      logic rx_cont;
      logic addr_det;
      logic tx_en;
   } sstx_mode_t;

   function automatic logic sstx_tx_active(sstx_mode_t m);
      return m.port_en & m.sync_mode & ~m.clk_master & ~m.rx_single &
             ~m.rx_cont & ~m.addr_det & m.tx_en;
   endfunction

endpackage

// File: rtl/sstx_sck_sync.sv
module sstx_sck_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_async,
   output logic sck_fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sstx_sck_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], sck_async};
         prev  <= chain[STAGES-1];
      end
   end

   assign sck_fall = prev & ~chain[STAGES-1];

   // one detected edge per transition
   assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sck_fall |=> !sck_fall);
endmodule

// File: rtl/sstx_hold_buf.sv
module sstx_hold_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wninth,
   input  logic              wnine_en,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] q_data,
   output logic              q_ninth,
   output logic              q_nine_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full      <= 1'b0;
         q_data    <= '0;
         q_ninth   <= 1'b0;
         q_nine_en <= 1'b0;
      end else if (clr) begin
         full <= 1'b0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr && !full) begin
         full      <= 1'b1;
         q_data    <= wdata;
         q_ninth   <= wninth;
         q_nine_en <= wnine_en;
      end
   end

   assert_full_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr && !take && !clr) |=> (full && q_data == $past(q_data)));
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fall,
   input  logic              avail,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              ld_ninth,
   input  logic              ld_nine_en,
   output logic              take,
   output logic              empty,
   output logic              sd
);
   localparam int FW = DATA_W + 1;
   localparam int CW = $clog2(FW + 1);

   logic [FW-1:0] sreg;
   logic [CW-1:0] cnt;
   logic [CW-1:0] len;
   logic          busy;
   logic          last;

   assign last = (cnt == len - CW'(1));
   assign take = !clr && avail && (!busy || (fall && last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         cnt  <= '0;
         len  <= '0;
         busy <= 1'b0;
      end else if (clr) begin
         busy <= 1'b0;
      end else if (take) begin
         sreg <= {ld_ninth, ld_data};
         len  <= ld_nine_en ? CW'(FW) : CW'(DATA_W);
         cnt  <= '0;
         busy <= 1'b1;
      end else if (busy && fall) begin
         if (last) begin
            busy <= 1'b0;
         end else begin
            sreg <= {1'b1, sreg[FW-1:1]};
            cnt  <= cnt + CW'(1);
         end
      end
   end

   assign empty = !busy;
   assign sd    = busy ? sreg[0] : 1'b1;

   assert_load_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !empty);
   assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt < len));
   assert_hold_between_edges_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fall && !clr) |=> $stable(sreg));
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
   import sstx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_port,
   input  logic              mode_sync,
   input  logic              clk_master,
   input  logic              rx_single,
   input  logic              rx_cont,
   input  logic              addr_detect,
   input  logic              en_tx,
   input  logic              nine_en,
   input  logic              ninth_bit,
   input  logic              irq_en,
   input  logic              hold_wr,
   input  logic [DATA_W-1:0] hold_wdata,
   input  logic              ext_sck,
   output logic              sd_out,
   output logic              sd_oe,
   output logic              ready_flag,
   output logic              shift_empty,
   output logic              irq
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sync_slave_tx: DATA_W must be at least 2");
      end
   endgenerate

   sstx_mode_t mode;
   logic       active;
   logic       fall;
   logic       hold_full;
   logic       take;
   logic [DATA_W-1:0] h_data;
   logic       h_ninth;
   logic       h_nine_en;
   logic       sd_raw;

   assign mode = '{port_en: en_port, sync_mode: mode_sync, clk_master: clk_master,
                   rx_single: rx_single, rx_cont: rx_cont, addr_det: addr_detect,
                   tx_en: en_tx};
   assign active = sstx_tx_active(mode);

   sstx_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_async (ext_sck),
      .sck_fall  (fall)
   );

   sstx_hold_buf #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (!active),
      .wr        (hold_wr),
      .wdata     (hold_wdata),
      .wninth    (ninth_bit),
      .wnine_en  (nine_en),
      .take      (take),
      .full      (hold_full),
      .q_data    (h_data),
      .q_ninth   (h_ninth),
      .q_nine_en (h_nine_en)
   );

   sstx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (!active),
      .fall       (fall),
      .avail      (hold_full),
      .ld_data    (h_data),
      .ld_ninth   (h_ninth),
      .ld_nine_en (h_nine_en),
      .take       (take),
      .empty      (shift_empty),
      .sd         (sd_raw)
   );

   assign sd_oe      = active;
   assign sd_out     = sd_raw;
   assign ready_flag = !hold_full;
   assign irq        = ready_flag & irq_en;

   assert_inactive_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (shift_empty && ready_flag));
   assert_empty_no_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(shift_empty) && $past(active)) |-> !$past(hold_full));
endmodule

// File: tb/sync_slave_tx_bench.sv
module sync_slave_tx_bench;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_port = 0, mode_sync = 0, clk_master = 0, rx_single = 0, rx_cont = 0;
   logic addr_detect = 0, en_tx = 0, nine_en = 0, ninth_bit = 0, irq_en = 0;
   logic hold_wr = 0;
   logic [DW-1:0] hold_wdata = '0;
   logic ext_sck = 1'b0;
   logic sd_out, sd_oe, ready_flag, shift_empty, irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   bit exp_q[$];

   always #2 clk = ~clk;

   sync_slave_tx #(.DATA_W(DW)) u_sync_slave_tx (
      .clk(clk), .rst_n(rst_n), .en_port(en_port), .mode_sync(mode_sync),
      .clk_master(clk_master), .rx_single(rx_single), .rx_cont(rx_cont),
      .addr_detect(addr_detect), .en_tx(en_tx), .nine_en(nine_en),
      .ninth_bit(ninth_bit), .irq_en(irq_en), .hold_wr(hold_wr),
      .hold_wdata(hold_wdata), .ext_sck(ext_sck), .sd_out(sd_out), .sd_oe(sd_oe),
      .ready_flag(ready_flag), .shift_empty(shift_empty), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_word(input logic [DW-1:0] d, input bit nine, input bit b9);
      for (int i = 0; i < DW; i++) exp_q.push_back(d[i]);
      if (nine) exp_q.push_back(b9);
   endtask

   task automatic write_word(input logic [DW-1:0] d);
      @(negedge clk);
      hold_wr = 1'b1;
      hold_wdata = d;
      @(negedge clk);
      hold_wr = 1'b0;
   endtask

   task automatic sck_bits(input int n);
      for (int i = 0; i < n; i++) begin
         ext_sck = 1'b1; cyc(8);
         ext_sck = 1'b0; cyc(8);
      end
   endtask

   task automatic set_active();
      @(negedge clk);
      en_port = 1; mode_sync = 1; clk_master = 0; rx_single = 0;
      rx_cont = 0; addr_detect = 0; en_tx = 1;
      cyc(2);
   endtask

   // monitor: the master samples on rising edges
   initial begin
      forever begin
         @(posedge ext_sck);
         if (exp_q.size() > 0) begin
            bit e;
            e = exp_q.pop_front();
            check(sd_out === e, "R5 R6 serial bit", sd_out, e);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // R2 reset state
      check(ready_flag === 1'b1, "R2 ready", ready_flag, 1);
      check(shift_empty === 1'b1, "R2 shift_empty", shift_empty, 1);
      check(irq === 1'b0, "R2 irq", irq, 0);
      check(sd_oe === 1'b0, "R2 sd_oe", sd_oe, 0);

      // R1 mode decode
      set_active();
      check(sd_oe === 1'b1, "R1 active", sd_oe, 1);
      for (int k = 0; k < 7; k++) begin
         @(negedge clk);
         case (k)
            0: en_port = 0;
            1: mode_sync = 0;
            2: clk_master = 1;
            3: rx_single = 1;
            4: rx_cont = 1;
            5: addr_detect = 1;
            default: en_tx = 0;
         endcase
         #1;
         check(sd_oe === 1'b0, "R1 inactive case", sd_oe, 0);
         set_active();
      end

      // R3 / R4 / R8 / R9
      irq_en = 1;
      push_word(8'hA5, 0, 0);
      write_word(8'hA5);
      cyc(2);
      check(shift_empty === 1'b0, "R3 loaded", shift_empty, 0);
      check(ready_flag === 1'b1, "R3 ready back", ready_flag, 1);
      check(sd_out === 1'b1, "R5 bit0 present", sd_out, 1);
      push_word(8'h3C, 0, 0);
      write_word(8'h3C);
      check(ready_flag === 1'b0, "R4 held ready low", ready_flag, 0);
      check(irq === 1'b0, "R8 irq low while full", irq, 0);
      sck_bits(8);
      check(ready_flag === 1'b1, "R4 ready after transfer", ready_flag, 1);
      check(shift_empty === 1'b0, "R4 still shifting", shift_empty, 0);
      check(irq === 1'b1, "R8 irq high", irq, 1);
      sck_bits(8);
      check(shift_empty === 1'b1, "R9 empty at end", shift_empty, 1);
      check(sd_out === 1'b1, "R5 idle high", sd_out, 1);
      irq_en = 0; #1;
      check(irq === 1'b0, "R8 irq masked", irq, 0);

      // R7 write while full ignored
      push_word(8'h96, 0, 0);
      write_word(8'h96);
      cyc(2);
      push_word(8'h0F, 0, 0);
      write_word(8'h0F);
      write_word(8'h55);
      check(ready_flag === 1'b0, "R7 still full", ready_flag, 0);
      push_word(8'hFF, 0, 0);   // idle line after both words
      sck_bits(24);
      check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
      check(shift_empty === 1'b1, "R7 idle after", shift_empty, 1);

      // R6 nine-bit frames
      nine_en = 1; ninth_bit = 1;
      push_word(8'h00, 1, 1);
      write_word(8'h00);
      ninth_bit = 0;
      push_word(8'hFF, 1, 0);
      write_word(8'hFF);
      nine_en = 0; ninth_bit = 1;
      sck_bits(18);
      check(shift_empty === 1'b1, "R6 two 9-bit frames done", shift_empty, 1);
      ninth_bit = 0;

      // R10 flush on disable, writes ignored while inactive
      for (int i = 0; i < 3; i++) exp_q.push_back(i == 1);
      write_word(8'h5A);
      cyc(2);
      push_word(8'h11, 0, 0);
      write_word(8'h11);
      sck_bits(3);
      @(negedge clk); en_tx = 0;
      cyc(2);
      check(sd_oe === 1'b0, "R10 oe off", sd_oe, 0);
      check(shift_empty === 1'b1, "R10 shifter flushed", shift_empty, 1);
      check(ready_flag === 1'b1, "R10 hold flushed", ready_flag, 1);
      exp_q.delete();
      write_word(8'h00);
      set_active();
      check(shift_empty === 1'b1, "R10 write ignored", shift_empty, 1);
      check(ready_flag === 1'b1, "R10 hold still empty", ready_flag, 1);
      push_word(8'hFF, 0, 0);
      sck_bits(8);

      // R11 write racing the word-ending reload
      for (int off = 0; off < 5; off++) begin
         logic [DW-1:0] w1, w2;
         w1 = 8'h81 ^ 8'(off * 37);
         w2 = 8'h6B ^ 8'(off * 19);
         push_word(w1, 0, 0);
         write_word(w1);
         cyc(2);
         sck_bits(7);
         ext_sck = 1'b1; cyc(8);
         ext_sck = 1'b0; cyc(off);
         push_word(w2, 0, 0);
         @(negedge clk); hold_wr = 1'b1; hold_wdata = w2;
         @(negedge clk); hold_wr = 1'b0;
         cyc(8);
         sck_bits(8);
         check(exp_q.size() == 0, "R11 both words sent", exp_q.size(), 0);
         check(shift_empty === 1'b1, "R11 idle after", shift_empty, 1);
      end

      cyc(4);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule